// File: doc/BRIEF.md
# Timer Channel Restart Trigger Controller

This block collects every event that may restart one timer channel and drives that channel's up-counter. Four sources can request a restart:
- a one-cycle software strobe;
- a sync strobe that the timer block sends to all channels in the same cycle;
- an optional match between the counter and a compare value;
- an edge on one of two external pins, with the pin and the edge chosen by configuration.

The external pins are asynchronous. They pass through a two-flop synchronizer clocked by the system clock, and edge detection runs on the synchronized values.

The counter does not advance on every system clock. It advances only on cycles where a counting-clock enable pulse is high, and that pulse may be much slower than the system clock. A restart request therefore does not act at once. It is held in a pending flag until the next enable pulse. On that pulse the counter is cleared, and the following enable pulses count up from zero. Because of this, the counter can read a non-zero value for some time after a trigger has been requested. Requests that arrive while one is already pending merge into a single restart.

Top module: `tc_trig_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0 and `trig_pending` is 0.
- R2: A one-cycle `sw_trig` with `cnt_en` low sets `trig_pending` after that clock edge and leaves `count` unchanged. At the next clock edge where `cnt_en` is high, `count` becomes 0.
- R3: A `sync_trig` strobe behaves exactly like `sw_trig`.
- R4: When `rc_trig_en` is 1 and `count` equals `rc_value`, a restart is requested. With `cnt_en` high every cycle, the count sequence is 0 up to `rc_value`, then 0 again.
- R5: When `rc_trig_en` is 0, `count` passes `rc_value` without restarting.
- R6: `ext_sel` = 0 selects `pin_a` as the external trigger source and `ext_sel` = 1 selects `pin_b`. Edges on the pin that is not selected have no effect.
- R7: `ext_edge` selects the edge that triggers: 0 = none (external trigger disabled), 1 = rising, 2 = falling, 3 = both.
- R8: Each pin is sampled on the system clock through two flops. A pin level that changes before clock edge N sets `trig_pending` after edge N+2, provided `cnt_en` is low at that edge. A level that does not survive until a sampling edge is not seen.
- R9: Any `cnt_en` cycle clears `trig_pending`. Several requests that arrive before that cycle cause one clear only.
- R10: `count` increments by 1 on each `cnt_en` cycle that has no restart, wraps from 0xFFFF to 0, and holds its value when `cnt_en` is low.
- R11: A request that is present in the same cycle as `cnt_en` clears `count` at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counting-clock enable pulse |
| sw_trig | input | 1 | Software restart strobe |
| sync_trig | input | 1 | Block-wide sync strobe |
| rc_trig_en | input | 1 | Enables restart on a compare match |
| rc_value | input | 16 | Compare value |
| ext_sel | input | 1 | External pin select (0 = pin_a, 1 = pin_b) |
| ext_edge | input | 2 | External edge select (0 none, 1 rise, 2 fall, 3 both) |
| pin_a | input | 1 | External input A (asynchronous) |
| pin_b | input | 1 | External input B (asynchronous) |
| count | output | 16 | Counter value |
| trig_pending | output | 1 | A restart is waiting for the next enable pulse |

## Verification
Most internal faults show up at the ports within a few cycles:
- A wrong pending flag shows on `trig_pending` one edge after the request that set it.
- A lost or extra restart shows on `count` at the very next `cnt_en` edge, as a zero where an increment was expected or the reverse.
- A synchronizer of the wrong depth, or a wrong edge decode, shifts or removes the pending assertion relative to the pin change. Checking every cycle against a model that tracks pin history exposes this within three edges.

A fault in the wrap logic only appears after 65536 enable pulses, so the bench runs one full lap.

// File: rtl/tc_trig_pkg.sv
// Shared types for the timer restart trigger controller.
package tc_trig_pkg;
    // External trigger edge selection encoding (R7).
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/tc_ext_edge.sv
// External trigger front end.
// What it does: synchronizes two asynchronous pins, selects one of them,
// and detects the programmed edge on it.
// Assumes: pins hold each level for more than one clk period; SYNC_STAGES >= 2.
module tc_ext_edge
    import tc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       ext_sel,
    input  logic [1:0] ext_edge,
    output logic       ext_hit
);
    localparam int CHAIN_W = SYNC_STAGES + 1;
    localparam int NUM_PINS = 2;

    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] synced;
    logic [NUM_PINS-1:0] prev;

    assign pins = {pin_b, pin_a};

    // One synchronizer chain per pin, plus one extra flop holding the previous level.
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_sync
        logic [CHAIN_W-1:0] chain;
        // Purpose: shift the pin level through the sync and history flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[CHAIN_W-2:0], pins[gi]};
        end
        assign synced[gi] = chain[SYNC_STAGES-1];
        assign prev[gi]   = chain[SYNC_STAGES];
    end

    logic sel_now, sel_old, rise, fall;
    edge_sel_e mode;

    assign sel_now = ext_sel ? synced[1] : synced[0];
    assign sel_old = ext_sel ? prev[1]   : prev[0];
    assign rise    = sel_now & ~sel_old;
    assign fall    = ~sel_now & sel_old;
    assign mode    = edge_sel_e'(ext_edge);

    // Purpose: decode the programmed edge into a trigger hit.
    always_comb begin
        unique case (mode)
            EDGE_RISE: ext_hit = rise;
            EDGE_FALL: ext_hit = fall;
            EDGE_BOTH: ext_hit = rise | fall;
            default:   ext_hit = 1'b0;
        endcase
    end

    p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge == 2'd0) |-> !ext_hit);
    p_rise_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge == 2'd1 && ext_hit) |-> sel_now);
    p_fall_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge == 2'd2 && ext_hit) |-> !sel_now);
endmodule

// File: rtl/tc_trig_merge.sv
// Trigger merge and pending logic.
// What it does: ORs all restart sources into one pending flag. The counter
// restarts on the first enable pulse that sees a pending or current request.
// Assumes: the strobes are one clk wide; cnt_en is a single-cycle pulse.
module tc_trig_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en,
    input  logic sw_trig,
    input  logic sync_trig,
    input  logic rc_hit,
    input  logic ext_hit,
    output logic pending,
    output logic restart
);
    logic any_req;

    assign any_req = sw_trig | sync_trig | rc_hit | ext_hit;
    assign restart = cnt_en & (pending | any_req);

    // Purpose: hold requests until the next counting-clock enable consumes them.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (cnt_en) pending <= 1'b0;
        else if (any_req) pending <= 1'b1;
    end

    p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !cnt_en) |=> pending);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !cnt_en) |=> pending);
    p_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> !pending);
endmodule

// File: rtl/tc_counter.sv
// Channel up-counter.
// What it does: counts on enable pulses, clears on restart, and wraps at full scale.
// Assumes: restart is only asserted together with cnt_en.
module tc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: clear on restart, otherwise increment on an enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else if (cnt_en)  count <= count + ONE;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));
    p_incr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !restart) |=> (count == $past(count) + ONE));
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && restart) |=> (count == '0));
endmodule

// File: rtl/tc_trig_ctrl.sv
// Timer channel restart trigger controller (top).
// What it does: combines the software, sync, compare and external restart
// sources and drives the channel counter.
// Assumes: cnt_en comes from clock selection logic outside this block.
module tc_trig_ctrl #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             sw_trig,
    input  logic             sync_trig,
    input  logic             rc_trig_en,
    input  logic [CNT_W-1:0] rc_value,
    input  logic             ext_sel,
    input  logic [1:0]       ext_edge,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic [CNT_W-1:0] count,
    output logic             trig_pending
);
    logic ext_hit, rc_hit, restart;

    // Compare match is a restart source only when enabled (R4, R5).
    assign rc_hit = rc_trig_en && (count == rc_value);

    tc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .ext_sel(ext_sel), .ext_edge(ext_edge), .ext_hit(ext_hit)
    );

    tc_trig_merge u_merge (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
        .sync_trig(sync_trig), .rc_hit(rc_hit), .ext_hit(ext_hit),
        .pending(trig_pending), .restart(restart)
    );

    tc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .restart(restart), .count(count)
    );

    p_rc_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_trig_en && count == rc_value && cnt_en) |=> (count == '0));
    p_rc_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rc_trig_en && !sw_trig && !sync_trig && !ext_hit && !trig_pending && cnt_en)
        |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: tb/tc_trig_ctrl_bench.sv
module tc_trig_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 0, sw_trig = 0, sync_trig = 0, rc_trig_en = 0;
    logic [15:0] rc_value = 16'hFFFF;
    logic        ext_sel = 0, pin_a = 0, pin_b = 0;
    logic [1:0]  ext_edge = 2'd0;
    logic [15:0] count;
    logic        trig_pending;

    int checks = 0, fails = 0;
    logic [15:0] m_cnt;
    logic        m_pend;
    logic [2:0]  ma, mb;

    always #5 clk = ~clk;

    tc_trig_ctrl u_tc_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
        .sync_trig(sync_trig), .rc_trig_en(rc_trig_en), .rc_value(rc_value),
        .ext_sel(ext_sel), .ext_edge(ext_edge), .pin_a(pin_a), .pin_b(pin_b),
        .count(count), .trig_pending(trig_pending)
    );

    // Edge hit per R6/R7/R8: sampled level two flops deep, compared with the one before.
    function automatic logic exp_hit(logic [2:0] a, logic [2:0] b, logic sel, logic [1:0] e);
        logic now_v, old_v;
        now_v = sel ? b[1] : a[1];
        old_v = sel ? b[2] : a[2];
        case (e)
            2'd1: return now_v & ~old_v;
            2'd2: return ~now_v & old_v;
            2'd3: return now_v ^ old_v;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag);
        checks++;
        if (count !== m_cnt || trig_pending !== m_pend) begin
            fails++;
            $display("FAIL %s: count=%0h pending=%0b expected count=%0h pending=%0b",
                     tag, count, trig_pending, m_cnt, m_pend);
        end
    endtask

    // One clock: advance the model from the current inputs, then compare after the edge.
    task automatic step(string tag);
        logic req;
        req = sw_trig | sync_trig | (rc_trig_en && m_cnt == rc_value)
              | exp_hit(ma, mb, ext_sel, ext_edge);
        if (cnt_en) begin
            m_cnt  = (m_pend | req) ? 16'h0 : m_cnt + 16'h1;
            m_pend = 1'b0;
        end else begin
            m_pend = m_pend | req;
        end
        ma = {ma[1:0], pin_a};
        mb = {mb[1:0], pin_b};
        @(posedge clk);
        #1;
        check(tag);
        @(negedge clk);
    endtask

    task automatic quiet();
        cnt_en = 0; sw_trig = 0; sync_trig = 0;
    endtask

    initial begin
        #(150000 * 10);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_cnt = 0; m_pend = 0; ma = 0; mb = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1;

        // R10: count and hold
        cnt_en = 1; repeat (5) step("R10 count");
        cnt_en = 0; repeat (3) step("R10 hold");

        // R2: software strobe pends, count held, then cleared
        sw_trig = 1; step("R2 set");
        sw_trig = 0; repeat (2) step("R2 pending held");
        cnt_en = 1; step("R2 clear");
        step("R2 count from zero");
        cnt_en = 0;

        // R3: sync strobe
        sync_trig = 1; step("R3 set");
        sync_trig = 0; cnt_en = 1; step("R3 clear");
        cnt_en = 0;

        // R9: several requests merge into one restart
        sw_trig = 1; step("R9 merge");
        sw_trig = 0; sync_trig = 1; step("R9 merge");
        sync_trig = 0; cnt_en = 1; step("R9 one clear");
        repeat (3) step("R9 counting after");
        quiet();

        // R11: request in the same cycle as enable
        repeat (2) begin cnt_en = 1; step("R11 pre"); end
        sw_trig = 1; step("R11 immediate");
        quiet(); step("R11 after");

        // R4: compare restart with continuous enable
        rc_value = 16'd4; rc_trig_en = 1; cnt_en = 1;
        repeat (14) step("R4 period");
        // R5: compare disabled
        rc_trig_en = 0;
        repeat (10) step("R5 ignored");
        quiet();

        // R6/R7/R8: each pin and edge mode
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 4; e++) begin
                ext_sel = s[0]; ext_edge = e[1:0];
                repeat (3) step("R7 settle");
                cnt_en = 1; step("R7 flush"); cnt_en = 0;
                pin_a = ~pin_a; step("R8 edge latency");
                repeat (3) step("R7 edge A");
                cnt_en = 1; step("R9 flush"); cnt_en = 0;
                pin_b = ~pin_b; repeat (4) step("R6 edge B");
                cnt_en = 1; step("R6 flush"); cnt_en = 0;
            end
        end

        // Random mix
        for (int i = 0; i < 20000; i++) begin
            cnt_en     = ($urandom % 4) == 0;
            sw_trig    = ($urandom % 64) == 0;
            sync_trig  = ($urandom % 64) == 0;
            rc_trig_en = ($urandom % 2) == 0;
            if ($urandom % 500 == 0) rc_value = 16'($urandom % 40);
            if ($urandom % 8 == 0) pin_a = ~pin_a;
            if ($urandom % 8 == 0) pin_b = ~pin_b;
            if ($urandom % 300 == 0) begin
                ext_sel = 1'($urandom);
                ext_edge = 2'($urandom);
            end
            step("R9 random");
        end

        // R10: full wrap
        quiet(); rc_trig_en = 0; ext_edge = 2'd0;
        sw_trig = 1; cnt_en = 1; step("R10 restart");
        sw_trig = 0;
        for (int i = 0; i < 65540; i++) step("R10 wrap");
        quiet(); step("R10 end");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule